// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block is a real-time-clock core. A free-running tick enable at the oscillator rate (32768 per second by default) feeds a prescaler. Each time the prescaler wraps, the calendar moves forward one second. Seconds, minutes, hours, day of month, month and a two-digit year are held as BCD bytes. The calendar follows month lengths, including February in leap years. A second set of six BCD bytes holds an alarm time. The alarm fires only when every one of the six fields matches the calendar.

Software reaches the block through a simple byte bus with a write strobe and a combinational read port. The block exposes the calendar, the alarm, a control byte with a run bit, a sticky event status byte, and an interrupt-enable byte.

The status byte carries a BUSY flag, which is high during the last tick interval before each seconds update. Software polls until BUSY is low and then has most of a tick interval in which it can access the registers safely. Two interrupt outputs combine the enables with the pending events.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the calendar reads 00:00:00 on day 01, month 01, year 00. The alarm bytes, control, status and interrupt-enable all read 0x00, and both interrupt outputs are low.
- R2: Calendar fields and the prescaler hold their values while control bit 0 (run) is 0. They advance only while that bit is 1.
- R3: While running, the seconds field advances once every PRESCALE tick enables. A bus write to the seconds byte restarts the prescaler, so the next advance comes PRESCALE ticks after that write.
- R4: Carries ripple in BCD through the fields. Seconds 59 and minutes 59 wrap to 00. Hours wrap from 23 to 00. Month wraps from 12 to 01. Year wraps from 99 to 00.
- R5: The day wraps to 01 after the last day of the current month. Months 04, 06, 09 and 11 have 30 days. February has 29 days when the year value is divisible by 4 (including 00) and 28 days otherwise. All other months have 31 days.
- R6: Status bits are set when their event occurs and stay set. Bit 2 is set on every seconds update. Bit 3 is set when seconds wrap. Bit 4 is set when minutes wrap. Bit 5 is set when hours wrap.
- R7: Status bit 6 is set by a seconds update only when all six updated calendar fields equal the six alarm bytes. A difference in any single field keeps it clear.
- R8: Writing status clears each event bit (bits 2 to 6) whose written data bit is 1. Bits written with 0 keep their value.
- R9: Status bit 0 (BUSY) is 1 exactly while the block is running and the prescaler is in its final tick interval before a seconds update. It is 0 at all other times.
- R10: The timer interrupt output equals interrupt-enable bit 2 AND status bit 2. The alarm interrupt output equals interrupt-enable bit 3 AND status bit 6.
- R11: Calendar bytes sit at 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14, in the order seconds, minutes, hours, day, month, year. Alarm bytes sit at 0x20 to 0x34 in the same order. Control is at 0x40, status at 0x44 and interrupt-enable at 0x48. A write to a calendar byte loads it on the next clock. Control keeps only bit 0 and interrupt-enable keeps only bits 2 and 3; all other bits read 0.
- R12: Status bit 1 reads the current value of the run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle pulse per oscillator period |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr, combinational |
| irqTimer | output | 1 | Periodic seconds interrupt |
| irqAlarm | output | 1 | Alarm interrupt |

## Verification
The hardest states to reach are the rare carry boundaries: year and month rollover at midnight on the last day of the year, and the three February cases. Letting these build up one second at a time would take years of ticks. The bench instead loads the calendar one second before each boundary, writing the seconds byte last so that the prescaler starts from a known phase. It then issues exactly PRESCALE ticks. The same preload method places the calendar one second before the alarm time. A run with one field of the alarm off by one then shows that the full compare has no wildcard.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int FIELDS = 6;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;

  localparam logic [7:0] ADDR_CTRL   = 8'h40;
  localparam logic [7:0] ADDR_STATUS = 8'h44;
  localparam logic [7:0] ADDR_IEN    = 8'h48;

  typedef logic [FIELDS-1:0][7:0] fieldVec_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic             step;
    logic [FIELDS-1:0] wrTime;
    logic [FIELDS-1:0] wrAlarm;
    logic [7:0]       data;
  } rtcStrobe_t;

  // Events from datapath back to control; bit order matches status bits 6..2
  typedef struct packed {
    logic alarmHit;
    logic dayWrap;
    logic hourWrap;
    logic minWrap;
    logic secTick;
  } rtcEvent_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return v + 8'd1;
  endfunction

  function automatic logic isLeap(input logic [7:0] yearBcd);
    logic [7:0] bin;
    bin = {4'd0, yearBcd[7:4]} * 8'd10 + {4'd0, yearBcd[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] lastDay(input logic [7:0] monBcd, input logic [7:0] yearBcd);
    case (monBcd)
      8'h02:                      return isLeap(yearBcd) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_calendar_dp.sv
module rtc_calendar_dp
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rtcStrobe_t strb,
  input  logic [2:0] rdIdx,
  input  logic       rdAlarm,
  output logic [7:0] rdField,
  output rtcEvent_t  events,
  output fieldVec_t  timeNow,
  output fieldVec_t  alarmNow
);

  // Wrap-to values and fixed upper limits per field (day limit is dynamic)
  localparam fieldVec_t FIELD_MIN = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
  localparam fieldVec_t FIELD_MAX = {8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59};

  fieldVec_t timeQ, alarmQ, nextTime;
  logic [FIELDS:0] carry;
  logic [FIELDS-1:0] atLimit;
  logic [7:0] dayLimit;

  always_comb begin
    dayLimit = lastDay(timeQ[F_MON], timeQ[F_YEAR]);
    carry[0] = strb.step;
    for (int i = 0; i < FIELDS; i++) begin
      logic [7:0] stepped;
      atLimit[i] = timeQ[i] == ((i == F_DAY) ? dayLimit : FIELD_MAX[i]);
      if (carry[i]) stepped = atLimit[i] ? FIELD_MIN[i] : bcdInc(timeQ[i]);
      else          stepped = timeQ[i];
      carry[i+1]  = carry[i] & atLimit[i];
      nextTime[i] = strb.wrTime[i] ? strb.data : stepped;
    end
  end

  always_comb begin
    events.secTick  = carry[F_SEC];
    events.minWrap  = carry[F_MIN];
    events.hourWrap = carry[F_HOUR];
    events.dayWrap  = carry[F_DAY];
    events.alarmHit = carry[F_SEC] && (nextTime == alarmQ);
  end

  for (genvar g = 0; g < FIELDS; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rstN) begin
        timeQ[g]  <= FIELD_MIN[g];
        alarmQ[g] <= 8'h00;
      end else begin
        timeQ[g] <= nextTime[g];
        if (strb.wrAlarm[g]) alarmQ[g] <= strb.data;
      end
    end
  end

  always_comb begin
    rdField = 8'h00;
    if (rdIdx < 3'(FIELDS)) rdField = rdAlarm ? alarmQ[rdIdx] : timeQ[rdIdx];
  end

  assign timeNow  = timeQ;
  assign alarmNow = alarmQ;

endmodule

// File: rtl/rtc_calendar_ctrl.sv
module rtc_calendar_ctrl
  import rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       wrEn,
  input  logic [7:0] addr,
  input  logic [7:0] wrData,
  input  rtcEvent_t  events,
  output rtcStrobe_t strb,
  output logic [2:0] rdIdx,
  output logic       rdAlarm,
  output logic       rdFromDp,
  output logic [7:0] rdCtrl,
  output logic       busyFlag,
  output logic       runFlag,
  output logic [4:0] evFlags,
  output logic       irqTimer,
  output logic       irqAlarm
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] preQ;
  logic             runQ;
  logic [1:0]       ienQ;
  logic [4:0]       evQ;
  logic             fieldHit, wrStatus;

  assign fieldHit = (addr[7:6] == 2'b00) && (addr[1:0] == 2'b00) && (addr[4:2] < 3'(FIELDS));
  assign wrStatus = wrEn && (addr == ADDR_STATUS);

  assign busyFlag = runQ && (preQ == PRE_LAST);

  always_comb begin
    strb.data    = wrData;
    strb.wrTime  = '0;
    strb.wrAlarm = '0;
    if (wrEn && fieldHit) begin
      if (addr[5]) strb.wrAlarm = FIELDS'(1) << addr[4:2];
      else         strb.wrTime  = FIELDS'(1) << addr[4:2];
    end
    // A seconds write wins over a pending update
    strb.step = tickEn && busyFlag && !strb.wrTime[F_SEC];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ <= '0;
      runQ <= 1'b0;
      ienQ <= 2'b00;
      evQ  <= 5'd0;
    end else begin
      if (strb.wrTime[F_SEC])    preQ <= '0;
      else if (tickEn && runQ)   preQ <= (preQ == PRE_LAST) ? '0 : preQ + PRE_W'(1);
      if (wrEn && addr == ADDR_CTRL) runQ <= wrData[0];
      if (wrEn && addr == ADDR_IEN)  ienQ <= wrData[3:2];
      // Set has priority over write-one-to-clear
      evQ <= (evQ & ~(wrStatus ? wrData[6:2] : 5'd0)) | events;
    end
  end

  assign rdIdx    = addr[4:2];
  assign rdAlarm  = addr[5];
  assign rdFromDp = fieldHit;

  always_comb begin
    case (addr)
      ADDR_CTRL:   rdCtrl = {7'd0, runQ};
      ADDR_STATUS: rdCtrl = {1'b0, evQ, runQ, busyFlag};
      ADDR_IEN:    rdCtrl = {4'd0, ienQ, 2'd0};
      default:     rdCtrl = 8'h00;
    endcase
  end

  assign runFlag  = runQ;
  assign evFlags  = evQ;
  assign irqTimer = ienQ[0] & evQ[0];
  assign irqAlarm = ienQ[1] & evQ[4];

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       wrEn,
  input  logic [7:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irqTimer,
  output logic       irqAlarm
);

  rtcStrobe_t strb;
  rtcEvent_t  events;
  fieldVec_t  timeNow, alarmNow;
  logic [2:0] rdIdx;
  logic       rdAlarm, rdFromDp, busyFlag, runFlag;
  logic [7:0] rdField, rdCtrl;
  logic [4:0] evFlags;

  rtc_calendar_ctrl #(.PRESCALE(PRESCALE)) i_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .events(events), .strb(strb), .rdIdx(rdIdx),
    .rdAlarm(rdAlarm), .rdFromDp(rdFromDp), .rdCtrl(rdCtrl),
    .busyFlag(busyFlag), .runFlag(runFlag), .evFlags(evFlags),
    .irqTimer(irqTimer), .irqAlarm(irqAlarm)
  );

  rtc_calendar_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdIdx(rdIdx), .rdAlarm(rdAlarm),
    .rdField(rdField), .events(events), .timeNow(timeNow), .alarmNow(alarmNow)
  );

  assign rdData = rdFromDp ? rdField : rdCtrl;

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       tickEn,
  input logic       wrEn,
  input logic [7:0] addr,
  input logic [7:0] wrData,
  input logic       busyFlag,
  input logic       runFlag,
  input logic [4:0] evFlags,
  input fieldVec_t  timeNow,
  input fieldVec_t  alarmNow
);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!runFlag && !wrEn) |=> $stable(timeNow));

  p_no_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !(tickEn && busyFlag)) |=> $stable(timeNow));

  p_busy_update_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busyFlag && tickEn && !wrEn) |=> evFlags[0]);

  p_sticky_alarm_r8: assert property (@(posedge clk) disable iff (!rstN)
    (evFlags[4] && !(wrEn && addr == ADDR_STATUS && wrData[6])) |=> evFlags[4]);

  p_alarm_match_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(evFlags[4]) && !$past(wrEn)) |-> (timeNow == alarmNow));

endmodule

bind rtc_calendar rtc_calendar_chk i_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
  .wrData(wrData), .busyFlag(busyFlag), .runFlag(runFlag),
  .evFlags(evFlags), .timeNow(timeNow), .alarmNow(alarmNow)
);

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;

  localparam int PS = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       irqTimer, irqAlarm;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_calendar #(.PRESCALE(PS)) i_rtc_calendar (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqTimer(irqTimer), .irqAlarm(irqAlarm)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic tick();
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
  endtask

  task automatic oneSecond();
    repeat (PS) tick();
  endtask

  // Seconds written last so the prescaler phase is zero
  task automatic setTime(input logic [7:0] y, mo, d, h, mi, s);
    wr(8'h14, y); wr(8'h10, mo); wr(8'h0C, d); wr(8'h08, h); wr(8'h04, mi); wr(8'h00, s);
  endtask

  task automatic setAlarm(input logic [7:0] y, mo, d, h, mi, s);
    wr(8'h34, y); wr(8'h30, mo); wr(8'h2C, d); wr(8'h28, h); wr(8'h24, mi); wr(8'h20, s);
  endtask

  task automatic checkTime(input string req, input logic [7:0] y, mo, d, h, mi, s);
    logic [7:0] v;
    rd(8'h14, v); check(req, "year", v, y);
    rd(8'h10, v); check(req, "month", v, mo);
    rd(8'h0C, v); check(req, "day", v, d);
    rd(8'h08, v); check(req, "hours", v, h);
    rd(8'h04, v); check(req, "minutes", v, mi);
    rd(8'h00, v); check(req, "seconds", v, s);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    checkTime("R1", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    rd(8'h20, v); check("R1", "alarm sec", v, 8'h00);
    rd(8'h30, v); check("R1", "alarm month", v, 8'h00);
    rd(8'h40, v); check("R1", "ctrl", v, 8'h00);
    rd(8'h44, v); check("R1", "status", v, 8'h00);
    rd(8'h48, v); check("R1", "ien", v, 8'h00);
    check("R1", "irqTimer", {7'd0, irqTimer}, 8'h00);
    check("R1", "irqAlarm", {7'd0, irqAlarm}, 8'h00);
  endtask

  task automatic t_stopped();
    logic [7:0] v;
    setTime(8'h23, 8'h05, 8'h14, 8'h10, 8'h20, 8'h30);
    repeat (3 * PS) tick();
    rd(8'h00, v); check("R2", "seconds while stopped", v, 8'h30);
    rd(8'h44, v); check("R2", "status while stopped", v, 8'h00);
  endtask

  task automatic t_prescale();
    logic [7:0] v;
    wr(8'h40, 8'hFF);
    rd(8'h40, v); check("R11", "ctrl keeps bit0 only", v, 8'h01);
    rd(8'h44, v); check("R12", "run bit in status", v, 8'h02);
    wr(8'h00, 8'h30);
    repeat (PS - 2) tick();
    rd(8'h44, v); check("R9", "busy before last interval", {7'd0, v[0]}, 8'h00);
    tick();
    rd(8'h44, v); check("R9", "busy in last interval", {7'd0, v[0]}, 8'h01);
    rd(8'h00, v); check("R3", "seconds before update", v, 8'h30);
    tick();
    rd(8'h00, v); check("R3", "seconds after PRESCALE ticks", v, 8'h31);
    rd(8'h44, v); check("R9", "busy after update", {7'd0, v[0]}, 8'h00);
    repeat (2) tick();
    wr(8'h00, 8'h40);
    repeat (PS - 1) tick();
    rd(8'h00, v); check("R3", "restart delays update", v, 8'h40);
    tick();
    rd(8'h00, v); check("R3", "update after restart", v, 8'h41);
  endtask

  task automatic t_carry();
    logic [7:0] v;
    wr(8'h44, 8'hFF);
    setTime(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    oneSecond();
    checkTime("R4", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    rd(8'h44, v); check("R6", "all periodic events", v, 8'h3E);
    wr(8'h44, 8'h04);
    rd(8'h44, v); check("R8", "clear bit2 only", v, 8'h3A);
    wr(8'h44, 8'h00);
    rd(8'h44, v); check("R8", "zero write keeps", v, 8'h3A);
    wr(8'h44, 8'hFF);
    rd(8'h44, v); check("R8", "clear all", v, 8'h02);
    setTime(8'h23, 8'h05, 8'h14, 8'h10, 8'h37, 8'h59);
    oneSecond();
    checkTime("R4", 8'h23, 8'h05, 8'h14, 8'h10, 8'h38, 8'h00);
    rd(8'h44, v); check("R6", "minute event only", v, 8'h0E);
    wr(8'h44, 8'hFF);
  endtask

  task automatic dayCase(input logic [7:0] y, mo, d, ey, emo, ed);
    setTime(y, mo, d, 8'h23, 8'h59, 8'h59);
    oneSecond();
    checkTime("R5", ey, emo, ed, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_month();
    dayCase(8'h24, 8'h02, 8'h28, 8'h24, 8'h02, 8'h29);
    dayCase(8'h24, 8'h02, 8'h29, 8'h24, 8'h03, 8'h01);
    dayCase(8'h23, 8'h02, 8'h28, 8'h23, 8'h03, 8'h01);
    dayCase(8'h00, 8'h02, 8'h28, 8'h00, 8'h02, 8'h29);
    dayCase(8'h23, 8'h04, 8'h30, 8'h23, 8'h05, 8'h01);
    dayCase(8'h23, 8'h01, 8'h31, 8'h23, 8'h02, 8'h01);
    wr(8'h44, 8'hFF);
  endtask

  task automatic t_alarm();
    logic [7:0] v;
    wr(8'h48, 8'hFF);
    rd(8'h48, v); check("R11", "ien keeps bits 2,3", v, 8'h0C);
    wr(8'h48, 8'h08);
    setAlarm(8'h23, 8'h06, 8'h15, 8'h08, 8'h00, 8'h00);
    rd(8'h2C, v); check("R11", "alarm day readback", v, 8'h15);
    wr(8'h44, 8'hFF);
    setTime(8'h23, 8'h06, 8'h15, 8'h07, 8'h59, 8'h59);
    oneSecond();
    rd(8'h44, v); check("R7", "alarm bit on match", {7'd0, v[6]}, 8'h01);
    check("R10", "irqAlarm asserted", {7'd0, irqAlarm}, 8'h01);
    wr(8'h44, 8'h40);
    rd(8'h44, v); check("R8", "alarm bit cleared", {7'd0, v[6]}, 8'h00);
    check("R10", "irqAlarm released", {7'd0, irqAlarm}, 8'h00);
    wr(8'h34, 8'h24);
    setTime(8'h23, 8'h06, 8'h15, 8'h07, 8'h59, 8'h59);
    oneSecond();
    rd(8'h44, v); check("R7", "year mismatch no alarm", {7'd0, v[6]}, 8'h00);
    check("R10", "irqAlarm stays low", {7'd0, irqAlarm}, 8'h00);
    wr(8'h44, 8'hFF);
  endtask

  task automatic t_timer();
    logic [7:0] v;
    wr(8'h48, 8'h04);
    check("R10", "irqTimer idle", {7'd0, irqTimer}, 8'h00);
    oneSecond();
    check("R10", "irqTimer on second", {7'd0, irqTimer}, 8'h01);
    wr(8'h48, 8'h00);
    check("R10", "irqTimer masked", {7'd0, irqTimer}, 8'h00);
    rd(8'h44, v); check("R6", "second event still pending", {7'd0, v[2]}, 8'h01);
    rd(8'h18, v); check("R11", "unmapped read", v, 8'h00);
    wr(8'h40, 8'h00);
    rd(8'h44, v); check("R12", "run bit cleared", {7'd0, v[1]}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_stopped();
    t_prescale();
    t_carry();
    t_month();
    t_alarm();
    t_timer();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule